// File: doc/BRIEF.md
# Three-Stage Instruction Fetch Pipeline

This block is the front of a small in-order core. It has three stages: fetch, decode and execute. The fetch stage issues an address to a synchronous instruction memory every clock. It pairs the word that comes back one cycle later with the address that produced it. Each address/word pair then moves one stage per clock, through a decode slot that only holds the pair and its valid bit, and into the execute slot. The execute slot reports the instruction, its address, and the value that a program reading the program counter would see.

Because fetch has already moved two instructions further on, that value is the instruction's own address plus two instruction lengths. An input selects instructions of 4 bytes or 2 bytes. The execute logic outside the block can send a redirect with a target address. The redirect empties the younger slots and restarts fetch at the target, so execute stays empty for two cycles. A stall input holds the whole pipe in place. A redirect in the same cycle overrides the stall.

Top module: `fetchPipe3`

## Requirements
- R1: Each address moves fetch → decode → execute one stage per rising edge. While `exValid` is high, `exInstr` is the memory word read from `exAddr`.
- R2: After reset, the first valid instruction appears in execute after the third rising edge. With no stall and no redirect, a new instruction arrives in execute on every clock after that.
- R3: With `narrowMode` low at an edge, the fetch address for the next instruction is the current one plus 4.
- R4: With `narrowMode` high at an edge, the fetch address for the next instruction is the current one plus 2.
- R5: With `narrowMode` low, `exPcRead` equals `exAddr` + 8.
- R6: With `narrowMode` high, `exPcRead` equals `exAddr` + 4.
- R7: A redirect empties the fetch and decode slots at the edge. Execute then shows no valid instruction for the next two cycles. In the third cycle the target is in execute, followed by the target plus one step.
- R8: `imemAddr` is the next fetch address. In a redirect cycle it is `redirectAddr`. The word for an address issued in one cycle is expected on `imemData` in the next cycle.
- R9: Reset sets the fetch address to 0 and clears every valid bit, so `exValid` is low.
- R10: While `stall` is high and `redirect` is low, every slot, the fetch address and all execute outputs hold their values, and `imemAddr` re-issues the address of the word in fetch. A redirect in the same cycle as a stall takes effect as if there were no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| narrowMode | input | 1 | 1: 2-byte instructions, 0: 4-byte instructions |
| stall | input | 1 | Hold all stages |
| redirect | input | 1 | Flush younger stages and refetch from `redirectAddr` |
| redirectAddr | input | AW | Redirect target address |
| imemAddr | output | AW | Instruction memory read address |
| imemData | input | IW | Instruction word, one cycle after its address |
| exValid | output | 1 | Execute slot holds an instruction |
| exInstr | output | IW | Instruction in execute |
| exAddr | output | AW | Address of the instruction in execute |
| exPcRead | output | AW | Program-counter value seen by the executing instruction |

## Verification
The bench compares every cycle against a slot-queue model across these scenarios:
- The fill after reset. An off-by-one in the fill shows up as `exValid` rising a cycle early or late.
- Redirects issued back-to-back, and a redirect raised together with a stall. A design that lets a flushed slot survive would report a stale address in the bubble cycles. One that honours the stall over the redirect would miss the target.
- Stalls held across several cycles. A design that advances the fetch address but not the returned word during a stall would pair an address with the wrong instruction.
- Switches between the two instruction widths. A wrong stride or PC-read offset shows in `imemAddr` and `exPcRead` in either mode.

// File: rtl/fetchPipePkg.sv
package fetchPipePkg;
  localparam int WIDE_BYTES   = 4;
  localparam int NARROW_BYTES = 2;

  typedef struct packed {
    logic move;        // advance every slot by one stage
    logic takeTarget;  // load redirect target into fetch
  } pipeStrobe_t;
endpackage

// File: rtl/fetchPipeCtrl.sv
module fetchPipeCtrl
  import fetchPipePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stall,
  input  logic        redirect,
  output pipeStrobe_t strobe,
  output logic        fValid,
  output logic        dValid,
  output logic        eValid
);
  always_comb begin
    strobe.takeTarget = redirect;
    strobe.move       = !redirect && !stall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fValid <= 1'b0;
      dValid <= 1'b0;
      eValid <= 1'b0;
    end else if (strobe.takeTarget) begin
      fValid <= 1'b1;
      dValid <= 1'b0;
      eValid <= 1'b0;
    end else if (strobe.move) begin
      fValid <= 1'b1;
      dValid <= fValid;
      eValid <= dValid;
    end
  end

  assert_redirect_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (fValid && !dValid && !eValid));

  assert_fill_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eValid) |-> $past(dValid));

  assert_stall_valids_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !redirect) |=> $stable({fValid, dValid, eValid}));
endmodule

// File: rtl/fetchPipeDatapath.sv
module fetchPipeDatapath
  import fetchPipePkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  pipeStrobe_t   strobe,
  input  logic          fValid,
  input  logic          narrowMode,
  input  logic [AW-1:0] redirectAddr,
  input  logic [IW-1:0] imemData,
  output logic [AW-1:0] imemAddr,
  output logic [AW-1:0] eAddr,
  output logic [IW-1:0] eInstr
);
  logic [AW-1:0] step;
  logic [AW-1:0] fetchPc;   // next address to issue
  logic [AW-1:0] fAddr;     // address whose word is on imemData
  logic [AW-1:0] dAddr;
  logic [IW-1:0] dInstr;

  assign step = narrowMode ? AW'(NARROW_BYTES) : AW'(WIDE_BYTES);

  // On a hold, re-issue the fetch-slot address so the returned word stays paired.
  always_comb begin
    if (strobe.takeTarget)  imemAddr = redirectAddr;
    else if (strobe.move)   imemAddr = fetchPc;
    else                    imemAddr = fAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc <= '0;
      fAddr   <= '0;
      dAddr   <= '0;
      dInstr  <= '0;
      eAddr   <= '0;
      eInstr  <= '0;
    end else if (strobe.takeTarget) begin
      fAddr   <= redirectAddr;
      fetchPc <= redirectAddr + step;
    end else if (strobe.move) begin
      fAddr   <= fetchPc;
      fetchPc <= fetchPc + step;
      dAddr   <= fAddr;
      dInstr  <= imemData;
      eAddr   <= dAddr;
      eInstr  <= dInstr;
    end
  end

  assert_fetch_stride_R3: assert property (@(posedge clk) disable iff (!rstN)
    fValid |-> ((fetchPc - fAddr) == AW'(WIDE_BYTES) ||
                (fetchPc - fAddr) == AW'(NARROW_BYTES)));
endmodule

// File: rtl/fetchPipePcView.sv
module fetchPipePcView
  import fetchPipePkg::*;
#(
  parameter int AW    = 32,
  parameter int AHEAD = 2
) (
  input  logic          narrowMode,
  input  logic [AW-1:0] execAddr,
  output logic [AW-1:0] pcRead
);
  localparam logic [AW-1:0] WIDE_OFF   = AW'(AHEAD * WIDE_BYTES);
  localparam logic [AW-1:0] NARROW_OFF = AW'(AHEAD * NARROW_BYTES);

  assign pcRead = execAddr + (narrowMode ? NARROW_OFF : WIDE_OFF);
endmodule

// File: rtl/fetchPipe3.sv
module fetchPipe3
  import fetchPipePkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          narrowMode,
  input  logic          stall,
  input  logic          redirect,
  input  logic [AW-1:0] redirectAddr,
  output logic [AW-1:0] imemAddr,
  input  logic [IW-1:0] imemData,
  output logic          exValid,
  output logic [IW-1:0] exInstr,
  output logic [AW-1:0] exAddr,
  output logic [AW-1:0] exPcRead
);
  pipeStrobe_t strobe;
  logic        fValid;
  logic        dValid;

  fetchPipeCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .redirect(redirect),
    .strobe(strobe), .fValid(fValid), .dValid(dValid), .eValid(exValid)
  );

  fetchPipeDatapath #(.AW(AW), .IW(IW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fValid(fValid),
    .narrowMode(narrowMode), .redirectAddr(redirectAddr), .imemData(imemData),
    .imemAddr(imemAddr), .eAddr(exAddr), .eInstr(exInstr)
  );

  fetchPipePcView #(.AW(AW), .AHEAD(2)) i_pcView (
    .narrowMode(narrowMode), .execAddr(exAddr), .pcRead(exPcRead)
  );

  assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !redirect) |=> ($stable(exAddr) && $stable(exInstr) && $stable(exValid)));

  assert_redirect_issue_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (imemAddr == redirectAddr));
endmodule

// File: tb/test_fetchPipe3.sv
module test_fetchPipe3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        narrowMode = 1'b0;
  logic        stall = 1'b0;
  logic        redirect = 1'b0;
  logic [31:0] redirectAddr = '0;
  logic [31:0] imemAddr;
  logic [31:0] imemData = '0;
  logic        exValid;
  logic [31:0] exInstr;
  logic [31:0] exAddr;
  logic [31:0] exPcRead;

  int nChecks = 0;
  int nFails  = 0;

  // model: slot[0]=fetch, slot[1]=decode, slot[2]=execute, -1 = empty
  int slot[$];
  int nextPc;
  int bubbleLeft;

  always #10 clk = ~clk;

  fetchPipe3 i_fetchPipe3 (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .stall(stall),
    .redirect(redirect), .redirectAddr(redirectAddr), .imemAddr(imemAddr),
    .imemData(imemData), .exValid(exValid), .exInstr(exInstr),
    .exAddr(exAddr), .exPcRead(exPcRead)
  );

  function automatic logic [31:0] wordAt(logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  // synchronous memory, one cycle latency (R8)
  always @(posedge clk) imemData <= wordAt(imemAddr);

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int stepNow();
    return narrowMode ? 2 : 4;
  endfunction

  // one clock: drive at negedge, check imemAddr, update model at edge, compare at next negedge
  task automatic cyc(bit st, bit rd, int tgt);
    string tag;
    stall = st;
    redirect = rd;
    redirectAddr = 32'(tgt);
    #1;
    if (rd)
      chk(imemAddr == 32'(tgt), "R8", "imemAddr on redirect", imemAddr, 32'(tgt));
    else if (st) begin
      if (slot[0] >= 0)
        chk(imemAddr == 32'(slot[0]), "R10", "imemAddr held", imemAddr, 32'(slot[0]));
    end else
      chk(imemAddr == 32'(nextPc), narrowMode ? "R4" : "R3", "imemAddr stride", imemAddr, 32'(nextPc));
    @(posedge clk);
    if (rd) begin
      slot = '{tgt, -1, -1};
      nextPc = tgt + stepNow();
      bubbleLeft = 3;
    end else if (!st) begin
      slot.push_front(nextPc);
      void'(slot.pop_back());
      nextPc = nextPc + stepNow();
      if (bubbleLeft > 0) bubbleLeft--;
    end
    @(negedge clk);
    if (rd || bubbleLeft > 0) tag = "R7";
    else if (st) tag = "R10";
    else tag = "R1";
    chk(exValid == (slot[2] >= 0), (slot[2] >= 0 && !st && !rd) ? "R2" : tag,
        "exValid", 32'(exValid), 32'(slot[2] >= 0));
    if (slot[2] >= 0) begin
      chk(exAddr == 32'(slot[2]), tag, "exAddr", exAddr, 32'(slot[2]));
      chk(exInstr == wordAt(32'(slot[2])), "R1", "exInstr", exInstr, wordAt(32'(slot[2])));
      chk(exPcRead == 32'(slot[2] + 2 * stepNow()), narrowMode ? "R6" : "R5",
          "exPcRead", exPcRead, 32'(slot[2] + 2 * stepNow()));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    slot = '{-1, -1, -1};
    nextPc = 0;
    bubbleLeft = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(exValid == 1'b0, "R9", "exValid in reset", 32'(exValid), 32'd0);
    chk(imemAddr == 32'd0, "R9", "imemAddr in reset", imemAddr, 32'd0);
    rstN = 1'b1;
    // R2 fill then steady flow, wide mode
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 0);
    // R10 stall held
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 0);
    // R7 redirect
    cyc(1'b0, 1'b1, 32'h100);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0);
    // R10 redirect wins over stall
    cyc(1'b1, 1'b1, 32'h200);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 0);
    // R4/R6 narrow mode
    narrowMode = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 0);
    cyc(1'b0, 1'b1, 32'h302);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0);
    // back-to-back redirects, stall during refill
    cyc(1'b0, 1'b1, 32'h400);
    cyc(1'b0, 1'b1, 32'h480);
    cyc(1'b1, 1'b0, 0);
    cyc(1'b1, 1'b0, 0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0);
    // back to wide mode
    narrowMode = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0);
    cyc(1'b0, 1'b1, 32'h1000);
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, 0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule